// File: doc/BRIEF.md
# Virtual Address Region Decoder

This block sorts every 32-bit virtual address issued by a processor core into one of six fixed address regions. For each access it decides the outcome. The address is either handed to the TLB translator, folded directly onto a 29-bit physical address, or passed through unchanged. It may also be refused with a fault.

The decision depends on four things:
- the region;
- whether the access is privileged;
- whether address translation is enabled;
- whether the access is an instruction fetch.

A probe flag lets software-style lookups ask about an address without raising a fault. Where the block would otherwise refuse a data access, a probe returns a zero address instead.

The decode is purely combinational. Its result is captured in a single output register, so every input set is answered exactly one clock later. When a translate request is raised, the physical address and access grant come from the TLB block, and this decoder drives zero on both.

Top module: `va_region_decoder`

## Requirements
- R1: One cycle after the inputs are sampled, `region_o` holds the region code:
  - 0 when bit 31 of the address is clear;
  - 1 for 0x80000000 to 0xBFFFFFFF;
  - 2 for 0xC0000000 to 0xDFFFFFFF;
  - 3 for 0xE0000000 to 0xE3FFFFFF;
  - 4 for 0xE4000000 to 0xEFFFFFFF;
  - 5 for 0xF0000000 to 0xFFFFFFFF.
- R2: Conditions are regions 0 or 2 with `xlat_en_i` high, in any mode. Then `xlat_req_o` is 1, while `grant_o`, `fault_o`, `fault_cause_o` and `pa_o` are 0. `xlat_req_o` is never 1 for any other region.
- R3: In regions 0 or 2 with `xlat_en_i` low, `pa_o` equals the address with bits 31:29 cleared, and `grant_o` is 1.
- R4: In region 3, `pa_o` equals the address unchanged and `grant_o` is 1, in any mode and with any translation or fetch setting.
- R5: A non-privileged access (`priv_i` low) to regions 1, 4 or 5 gives:
  - `fault_o` 1 and `fault_cause_o` 1 without probe;
  - with `probe_i` high, `fault_o` 0 and `fault_cause_o` 0.

  In both cases `grant_o` and `pa_o` are 0.
- R6: A privileged access to region 1, fetch or data, gives `pa_o` equal to the address with bits 31:29 cleared, and `grant_o` 1.
- R7: A privileged instruction fetch in regions 4 or 5 gives `fault_o` 1 and `fault_cause_o` 2 whether or not `probe_i` is set. `grant_o` and `pa_o` are 0.
- R8: A privileged data access in region 5 passes the address through unchanged with `grant_o` 1.
- R9: A privileged data access in region 4 gives:
  - `fault_o` 1 and `fault_cause_o` 3 without probe;
  - with `probe_i` high, no fault and cause 0.

  In both cases `pa_o` and `grant_o` are 0.
- R10: While `rst` is high, all outputs are 0 on the next clock edge. `grant_o` and `fault_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| va_i | input | 32 | Virtual address |
| priv_i | input | 1 | Privileged mode when high |
| xlat_en_i | input | 1 | Address translation enabled |
| ifetch_i | input | 1 | Access is an instruction fetch |
| probe_i | input | 1 | Probe lookup: suppress data-access faults |
| region_o | output | 3 | Region code (R1 encoding) |
| xlat_req_o | output | 1 | Address must go to the TLB translator |
| pa_o | output | 32 | Physical or pass-through address |
| grant_o | output | 1 | Read-write access granted by this decoder |
| fault_o | output | 1 | Access refused |
| fault_cause_o | output | 2 | 0 none, 1 user-mode illegal, 2 illegal fetch, 3 unmapped hole |

## Verification
The block holds no state beyond its output register, so a wrong decode appears at the ports exactly one cycle after the offending inputs. The first exposure is a mismatched region code, address, grant or fault. A misplaced region boundary only shows at addresses next to it. For that reason the stimulus walks both ends of every region under all sixteen control combinations before random traffic. A policy branch taken in the wrong order shows as the wrong fault cause, for example a user-mode fetch in the control window reporting an illegal fetch instead of a user fault.

// File: rtl/va_region_pkg.sv
package va_region_pkg;

    localparam int VA_W = 32;
    localparam int PA_W = 29;

    localparam logic [VA_W-1:0] PA_MASK = VA_W'((64'd1 << PA_W) - 64'd1);

    typedef enum logic [2:0] {
        RGN_USER   = 3'd0,
        RGN_DIRECT = 3'd1,
        RGN_KVIRT  = 3'd2,
        RGN_SQ     = 3'd3,
        RGN_HOLE   = 3'd4,
        RGN_CTRL   = 3'd5
    } region_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_USER  = 2'd1,
        FLT_FETCH = 2'd2,
        FLT_HOLE  = 2'd3
    } fault_e;

    typedef struct packed {
        logic priv;
        logic xlat_en;
        logic ifetch;
        logic probe;
    } access_ctl_t;

    typedef struct packed {
        region_e          region;
        logic             xlat_req;
        logic [VA_W-1:0]  pa;
        logic             grant;
        fault_e           cause;
    } outcome_t;

    localparam outcome_t OUTCOME_IDLE = '{
        region:   RGN_USER,
        xlat_req: 1'b0,
        pa:       '0,
        grant:    1'b0,
        cause:    FLT_NONE
    };

    function automatic logic is_translatable(region_e r);
        return (r == RGN_USER) || (r == RGN_KVIRT);
    endfunction

    function automatic logic [VA_W-1:0] fold_direct(logic [VA_W-1:0] va);
        return va & PA_MASK;
    endfunction

endpackage

// File: rtl/va_region_classify.sv
module va_region_classify
    import va_region_pkg::*;
(
    input  logic [VA_W-1:0] va_i,
    output region_e         region_o
);
    // Region boundaries sit on power-of-two prefixes of the top address bits.
    localparam int TOP = VA_W - 1;

    logic [5:0] prefix;
    assign prefix = va_i[TOP -: 6];

    always_comb begin
        if (!prefix[5])                     region_o = RGN_USER;
        else if (prefix[5:4] == 2'b10)      region_o = RGN_DIRECT;
        else if (prefix[5:3] == 3'b110)     region_o = RGN_KVIRT;
        else if (prefix == 6'b111000)       region_o = RGN_SQ;
        else if (prefix[5:2] == 4'b1111)    region_o = RGN_CTRL;
        else                                region_o = RGN_HOLE;
    end

endmodule

// File: rtl/va_region_policy.sv
module va_region_policy
    import va_region_pkg::*;
(
    input  logic [VA_W-1:0] va_i,
    input  region_e         region_i,
    input  access_ctl_t     ctl_i,
    output outcome_t        out_o
);
    always_comb begin
        out_o        = OUTCOME_IDLE;
        out_o.region = region_i;

        if (is_translatable(region_i)) begin
            if (ctl_i.xlat_en) begin
                out_o.xlat_req = 1'b1;
            end else begin
                out_o.pa    = fold_direct(va_i);
                out_o.grant = 1'b1;
            end
        end else if (region_i == RGN_SQ) begin
            out_o.pa    = va_i;
            out_o.grant = 1'b1;
        end else if (!ctl_i.priv) begin
            if (!ctl_i.probe)
                out_o.cause = FLT_USER;
        end else begin
            unique case (region_i)
                RGN_DIRECT: begin
                    out_o.pa    = fold_direct(va_i);
                    out_o.grant = 1'b1;
                end
                RGN_CTRL: begin
                    if (ctl_i.ifetch) begin
                        out_o.cause = FLT_FETCH;
                    end else begin
                        out_o.pa    = va_i;
                        out_o.grant = 1'b1;
                    end
                end
                default: begin
                    if (ctl_i.ifetch)
                        out_o.cause = FLT_FETCH;
                    else if (!ctl_i.probe)
                        out_o.cause = FLT_HOLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/va_region_stage.sv
module va_region_stage
    import va_region_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  outcome_t d_i,
    output outcome_t q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= OUTCOME_IDLE;
        else     q_o <= d_i;
    end

endmodule

// File: rtl/va_region_decoder.sv
module va_region_decoder
    import va_region_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] va_i,
    input  logic        priv_i,
    input  logic        xlat_en_i,
    input  logic        ifetch_i,
    input  logic        probe_i,
    output logic [2:0]  region_o,
    output logic        xlat_req_o,
    output logic [31:0] pa_o,
    output logic        grant_o,
    output logic        fault_o,
    output logic [1:0]  fault_cause_o
);
    region_e     region_c;
    access_ctl_t ctl_c;
    outcome_t    outcome_c;
    outcome_t    outcome_q;

    assign ctl_c = '{priv: priv_i, xlat_en: xlat_en_i, ifetch: ifetch_i, probe: probe_i};

    va_region_classify u_classify (
        .va_i     (va_i),
        .region_o (region_c)
    );

    va_region_policy u_policy (
        .va_i     (va_i),
        .region_i (region_c),
        .ctl_i    (ctl_c),
        .out_o    (outcome_c)
    );

    va_region_stage u_stage (
        .clk (clk),
        .rst (rst),
        .d_i (outcome_c),
        .q_o (outcome_q)
    );

    assign region_o      = outcome_q.region;
    assign xlat_req_o    = outcome_q.xlat_req;
    assign pa_o          = outcome_q.pa;
    assign grant_o       = outcome_q.grant;
    assign fault_cause_o = outcome_q.cause;
    assign fault_o       = (outcome_q.cause != FLT_NONE);

endmodule

// File: rtl/va_region_decoder_chk.sv
module va_region_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] va_i,
    input logic        priv_i,
    input logic        xlat_en_i,
    input logic        ifetch_i,
    input logic        probe_i,
    input logic [2:0]  region_o,
    input logic        xlat_req_o,
    input logic [31:0] pa_o,
    input logic        grant_o,
    input logic        fault_o,
    input logic [1:0]  fault_cause_o
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_XLAT_REGION: assert property (@(posedge clk) disable iff (rst)
        xlat_req_o |-> (region_o == 3'd0 || region_o == 3'd2)); // R2

    AST_XLAT_QUIET: assert property (@(posedge clk) disable iff (rst)
        xlat_req_o |-> (!grant_o && !fault_o && pa_o == 32'd0)); // R2

    AST_GRANT_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(grant_o && fault_o)); // R10

    AST_SQ_PASS: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(va_i[31:26]) == 6'b111000) |-> (grant_o && pa_o == $past(va_i))); // R4

    AST_USER_FAULT: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(!priv_i && !probe_i && va_i[31] && va_i[31:26] != 6'b111000
               && va_i[31:29] != 3'b110)) |-> (fault_o && fault_cause_o == 2'd1)); // R5

    AST_DIRECT_FOLD: assert property (@(posedge clk) disable iff (rst)
        (region_o == 3'd1 && grant_o) |-> (pa_o[31:29] == 3'b000)); // R6

    AST_FETCH_FAULT: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(priv_i && ifetch_i && va_i[31:28] >= 4'hE && va_i[31:26] != 6'b111000))
        |-> (fault_cause_o == 2'd2)); // R7

endmodule

bind va_region_decoder va_region_decoder_chk u_chk (.*);

// File: tb/va_region_decoder_test.sv
`timescale 1ns/1ps
module va_region_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] va_i = '0;
    logic        priv_i = 1'b0;
    logic        xlat_en_i = 1'b0;
    logic        ifetch_i = 1'b0;
    logic        probe_i = 1'b0;
    logic [2:0]  region_o;
    logic        xlat_req_o;
    logic [31:0] pa_o;
    logic        grant_o;
    logic        fault_o;
    logic [1:0]  fault_cause_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    va_region_decoder uut (.*);

    // Expected outcome of the previously applied inputs
    int          e_rg;
    logic        e_xr;
    logic [31:0] e_pa;
    logic        e_g;
    int          e_c;
    string       e_tag;
    bit          have_prev = 0;

    task automatic model(input logic [31:0] a, input logic p, input logic x,
                         input logic f, input logic pr);
        longint ua;
        ua = longint'(a);
        if (ua < 64'h8000_0000)      e_rg = 0;
        else if (ua < 64'hC000_0000) e_rg = 1;
        else if (ua < 64'hE000_0000) e_rg = 2;
        else if (ua < 64'hE400_0000) e_rg = 3;
        else if (ua < 64'hF000_0000) e_rg = 4;
        else                         e_rg = 5;
        e_xr = 0; e_pa = 0; e_g = 0; e_c = 0;
        if (e_rg == 0 || e_rg == 2) begin
            if (x) begin e_xr = 1; e_tag = "R2"; end
            else begin e_pa = a % 32'h2000_0000; e_g = 1; e_tag = "R3"; end
        end else if (e_rg == 3) begin
            e_pa = a; e_g = 1; e_tag = "R4";
        end else if (!p) begin
            if (!pr) e_c = 1;
            e_tag = "R5";
        end else if (e_rg == 1) begin
            e_pa = a % 32'h2000_0000; e_g = 1; e_tag = "R6";
        end else if (f) begin
            e_c = 2; e_tag = "R7";
        end else if (e_rg == 5) begin
            e_pa = a; e_g = 1; e_tag = "R8";
        end else begin
            if (!pr) e_c = 3;
            e_tag = "R9";
        end
    endtask

    task automatic compare();
        checks++;
        if (int'(region_o) != e_rg) begin
            errors++;
            $display("FAIL R1 region actual=%0d expected=%0d", region_o, e_rg);
        end
        checks++;
        if (xlat_req_o !== e_xr || pa_o !== e_pa || grant_o !== e_g ||
            int'(fault_cause_o) != e_c || fault_o !== (e_c != 0)) begin
            errors++;
            $display("FAIL %s actual xr=%0b pa=%h g=%0b f=%0b c=%0d expected xr=%0b pa=%h g=%0b f=%0b c=%0d",
                     e_tag, xlat_req_o, pa_o, grant_o, fault_o, fault_cause_o,
                     e_xr, e_pa, e_g, (e_c != 0), e_c);
        end
    endtask

    task automatic step(input logic [31:0] a, input logic [3:0] ctl);
        @(negedge clk);
        if (have_prev) compare();
        va_i      = a;
        priv_i    = ctl[3];
        xlat_en_i = ctl[2];
        ifetch_i  = ctl[1];
        probe_i   = ctl[0];
        model(a, ctl[3], ctl[2], ctl[1], ctl[0]);
        have_prev = 1;
    endtask

    logic [31:0] corners [12] = '{
        32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'hBFFF_FFFF,
        32'hC000_0000, 32'hDFFF_FFFF, 32'hE000_0000, 32'hE3FF_FFFF,
        32'hE400_0000, 32'hEFFF_FFFF, 32'hF000_0000, 32'hFFFF_FFFF
    };

    initial begin
        // Reset state, driven with inputs that would otherwise grant (R10)
        va_i = 32'hF000_1234; priv_i = 1; xlat_en_i = 0; ifetch_i = 0; probe_i = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (region_o !== 3'd0 || xlat_req_o !== 1'b0 || pa_o !== 32'd0 ||
            grant_o !== 1'b0 || fault_o !== 1'b0 || fault_cause_o !== 2'd0) begin
            errors++;
            $display("FAIL R10 reset actual rg=%0d xr=%0b pa=%h g=%0b f=%0b expected all zero",
                     region_o, xlat_req_o, pa_o, grant_o, fault_o);
        end
        rst = 0;

        for (int i = 0; i < 12; i++)
            for (int c = 0; c < 16; c++)
                step(corners[i], 4'(c));

        for (int n = 0; n < 3000; n++)
            step($urandom(), 4'($urandom()));

        @(negedge clk);
        compare();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule